// File: doc/BRIEF.md
# Qualified Fault Input Latch

This block guards a PWM generator against external fault conditions. It watches four asynchronous fault pins and brings each one into the clock domain through a two-flop synchronizer. On every sample-enable strobe it checks the synchronized level, and it accepts a fault only after a programmable run of consecutive high samples. Each qualified fault sets a sticky per-channel flag. The flag stays set until software clears it by writing a one, and the block raises an interrupt request for any flagged channel whose interrupt is enabled.

Software reaches the block through a small write port and a combinational read port. The port holds four registers: pin enables, qualifying-sample selects, fault flags and interrupt enables. A lock request input freezes the enable and sample-select registers until the next reset. The block exports the qualified level of each channel and the latched flags. Disabling PWM outputs is left to the logic that consumes these signals.

Top module: `fltq_latch`

## Requirements
- R1: After reset, all four registers read 0, `irq` is low, and `fault_lvl` and `fault_flag` are 0.
- R2: Register map on `wr_addr`/`rd_addr`. Address 0 holds the pin enables, with channel i at bit i. Address 1 holds the sample selects, with channel i at bits [2i+1:2i]. Address 2 holds the flags, with channel i at bit i. Address 3 holds the interrupt enables, with channel i at bit i. Bits [7:4] of addresses 0, 2 and 3 read 0.
- R3: Select codes 0, 1, 2 and 3 require 1, 3, 5 and 7 consecutive high samples. A flag sets on the strobe that completes the run. With `smp_en` held high, a pin that rises before clock edge 1 gives a set flag after edge N+2 and a clear flag after edge N+1, where N is the required run.
- R4: A low sample taken before the run completes restarts that channel's count from zero.
- R5: A fault sets the flag once per rising edge. If the pin stays high after the flag is cleared, the flag stays clear until the pin goes low and qualifies again.
- R6: While a channel's enable bit is 0, its pin is ignored: its flag does not set, its `fault_lvl` bit is 0 and its count is cleared.
- R7: Writing 1 to a flag bit at address 2 clears that bit. Writing 0 leaves it unchanged.
- R8: A set flag stays set after the pin goes low, until it is cleared by a write.
- R9: When a flag set and a write-one-to-clear of the same bit fall on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly when some channel has both its flag and its interrupt enable set. Clearing the flag drops the request.
- R11: A high `cfg_lock` at a clock edge locks the block until reset. After that edge, writes to addresses 0 and 1 are ignored and those registers stay readable. Addresses 2 and 3 remain writable.
- R12: `fault_lvl[i]` is high while channel i is enabled and its current run has reached the required length. It falls after the first low sample.
- R13: No sample is taken and no count advances on cycles where `smp_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | 4 | Asynchronous fault inputs, one per channel |
| smp_en | input | 1 | Sample strobe |
| cfg_lock | input | 1 | Lock request for the configuration registers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| fault_lvl | output | 4 | Qualified fault level per channel |
| fault_flag | output | 4 | Latched fault flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that flags persist, that flags never rise without a qualified set, that a same-edge set beats a clear, that a write-one clears, that the lock freezes the configuration, and that a low sample or a disabled channel empties the count. Only the bench scenarios show the exact edge on which a flag appears for each select code. The same holds for one set per rising edge with a pin held high, for disabled pins and missing strobes having no effect, and for how the interrupt follows flags and enables. A random phase compares every register read, flag, level and interrupt with a bench model.

// File: rtl/fltq_pkg.sv
package fltq_pkg;

    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_ENABLE = 2'd0,
        RA_QSEL   = 2'd1,
        RA_FLAG   = 2'd2,
        RA_IRQEN  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/fltq_sync.sv
module fltq_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;

endmodule

// File: rtl/fltq_qual.sv
module fltq_qual #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             smp_en_i,
    input  logic             pin_s_i,
    output logic             fire_o,
    output logic             lvl_o
);

    localparam int unsigned CNT_W = SEL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_state_t;

    qual_state_t      st_d, st_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        need    = {sel_i, 1'b1};
        cnt_inc = st_q.cnt + CNT_W'(1);
        st_d    = st_q;
        fire_o  = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (smp_en_i) begin
            if (!pin_s_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt < need) begin
                st_d.cnt = cnt_inc;
                fire_o   = (cnt_inc == need);
            end
        end
        lvl_o = en_i && (st_q.cnt >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LOW_SAMPLE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && smp_en_i && !pin_s_i) |=> (st_q.cnt == '0)); // R4

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (st_q.cnt == '0)); // R6

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !smp_en_i) |=> $stable(st_q.cnt)); // R13

endmodule

// File: rtl/fltq_regs.sv
module fltq_regs
    import fltq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [REG_AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    lock_req,
    input  logic [NUM_CH-1:0]       set_i,
    output logic [NUM_CH-1:0]       en_o,
    output logic [NUM_CH*SEL_W-1:0] sel_o,
    output logic [NUM_CH-1:0]       ie_o,
    output logic [NUM_CH-1:0]       flag_o
);

    localparam int unsigned SELS_W = NUM_CH * SEL_W;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [SELS_W-1:0] sel;
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] flag;
        logic              lock;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic [NUM_CH-1:0] clr;
    logic              wr_flag;

    always_comb begin
        st_d    = st_q;
        wr_flag = wr_en && (wr_addr == RA_FLAG);
        clr     = wr_flag ? wr_data[NUM_CH-1:0] : '0;
        if (wr_en && !st_q.lock && (wr_addr == RA_ENABLE)) st_d.en  = wr_data[NUM_CH-1:0];
        if (wr_en && !st_q.lock && (wr_addr == RA_QSEL))   st_d.sel = wr_data[SELS_W-1:0];
        if (wr_en && (wr_addr == RA_IRQEN))                st_d.ie  = wr_data[NUM_CH-1:0];
        st_d.flag = (st_q.flag & ~clr) | set_i;
        st_d.lock = st_q.lock | lock_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_ENABLE: rd_data = DATA_W'(st_q.en);
            RA_QSEL:   rd_data = DATA_W'(st_q.sel);
            RA_FLAG:   rd_data = DATA_W'(st_q.flag);
            RA_IRQEN:  rd_data = DATA_W'(st_q.ie);
            default:   rd_data = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign sel_o  = st_q.sel;
    assign ie_o   = st_q.ie;
    assign flag_o = st_q.flag;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == RA_FLAG)) |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag))); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RA_FLAG) && (set_i == '0)) |=> ((st_q.flag & $past(wr_data[NUM_CH-1:0])) == '0)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q.flag & $past(set_i)) == $past(set_i))); // R9

    AST_FLAG_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.flag & ~$past(st_q.flag) & ~$past(set_i)) == '0)); // R3

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> (st_q.lock && $stable(st_q.en) && $stable(st_q.sel))); // R11

endmodule

// File: rtl/fltq_latch.sv
module fltq_latch
    import fltq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned SEL_W  = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fault_pin,
    input  logic              smp_en,
    input  logic              cfg_lock,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] fault_lvl,
    output logic [NUM_CH-1:0] fault_flag,
    output logic              irq
);

    logic [NUM_CH-1:0]       pin_s;
    logic [NUM_CH-1:0]       fire;
    logic [NUM_CH-1:0]       en;
    logic [NUM_CH-1:0]       ie;
    logic [NUM_CH*SEL_W-1:0] sel;

    fltq_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_pin),
        .sync_o  (pin_s)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        fltq_qual #(.SEL_W(SEL_W)) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en[ch]),
            .sel_i    (sel[ch*SEL_W +: SEL_W]),
            .smp_en_i (smp_en),
            .pin_s_i  (pin_s[ch]),
            .fire_o   (fire[ch]),
            .lvl_o    (fault_lvl[ch])
        );
    end

    fltq_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lock_req (cfg_lock),
        .set_i    (fire),
        .en_o     (en),
        .sel_o    (sel),
        .ie_o     (ie),
        .flag_o   (fault_flag)
    );

    assign irq = |(fault_flag & ie);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fault_flag != '0)); // R10

endmodule

// File: tb/fltq_latch_tb.sv
module fltq_latch_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fault_pin = '0;
    logic       smp_en = 1'b0;
    logic       cfg_lock = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] fault_lvl;
    logic [3:0] fault_flag;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit use_model = 0;

    // bench reference state
    logic [3:0] m_en, m_ie, m_flag, m_s1, m_s2;
    logic [7:0] m_sel;
    logic       m_lock;
    int         m_cnt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    fltq_latch u_dut (
        .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .smp_en(smp_en),
        .cfg_lock(cfg_lock), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fault_lvl(fault_lvl),
        .fault_flag(fault_flag), .irq(irq)
    );

    function automatic int need_of(input logic [1:0] code);
        return 2 * int'(code) + 1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {4'h0, m_en};
            2'd1: return m_sel;
            2'd2: return {4'h0, m_flag};
            default: return {4'h0, m_ie};
        endcase
    endfunction

    function automatic logic [3:0] exp_lvl();
        logic [3:0] v;
        for (int i = 0; i < 4; i++)
            v[i] = m_en[i] && (m_cnt[i] >= need_of(m_sel[2*i +: 2]));
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = '0; m_ie = '0; m_flag = '0; m_s1 = '0; m_s2 = '0; m_sel = '0; m_lock = 1'b0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    endtask

    task automatic model_step();
        logic [3:0] set, clr;
        set = '0;
        for (int i = 0; i < 4; i++) begin
            int nd;
            nd = need_of(m_sel[2*i +: 2]);
            if (!m_en[i]) m_cnt[i] = 0;
            else if (smp_en) begin
                if (!m_s2[i]) m_cnt[i] = 0;
                else if (m_cnt[i] < nd) begin
                    m_cnt[i]++;
                    if (m_cnt[i] == nd) set[i] = 1'b1;
                end
            end
        end
        clr = (wr_en && wr_addr == 2'd2) ? wr_data[3:0] : 4'h0;
        m_flag = (m_flag & ~clr) | set;
        if (wr_en && !m_lock && wr_addr == 2'd0) m_en = wr_data[3:0];
        if (wr_en && !m_lock && wr_addr == 2'd1) m_sel = wr_data;
        if (wr_en && wr_addr == 2'd3) m_ie = wr_data[3:0];
        m_lock = m_lock | cfg_lock;
        m_s2 = m_s1;
        m_s1 = fault_pin;
    endtask

    // one clock: inputs already driven; returns at the next falling edge
    task automatic tick();
        @(posedge clk);
        if (use_model) model_step();
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fault_pin = '0; smp_en = 1'b0; cfg_lock = 1'b0; wr_en = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_chk("R1 reset reg", 2'(a), 8'h00);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset lvl", fault_lvl, 0);
        chk("R1 reset flag", fault_flag, 0);

        // random phase against bench model
        use_model = 1;
        void'($urandom(32'd1357));
        for (int c = 0; c < 1500; c++) begin
            for (int i = 0; i < 4; i++)
                if ($urandom_range(7) == 0) fault_pin[i] = ~fault_pin[i];
            smp_en  = ($urandom_range(3) != 0);
            wr_en   = ($urandom_range(7) == 0);
            wr_addr = 2'($urandom_range(3));
            wr_data = 8'($urandom);
            if (wr_addr == 2'd0) wr_data[3:0] = wr_data[3:0] | 4'h9;
            cfg_lock = (c > 1300) && ($urandom_range(15) == 0);
            rd_addr = 2'($urandom_range(3));
            tick();
            #1;
            chk("R2 R3 R11 random read", rd_data, exp_rd(rd_addr));
            chk("R3 R7 random flag", fault_flag, m_flag);
            chk("R12 random lvl", fault_lvl, exp_lvl());
            chk("R10 random irq", irq, |(m_flag & m_ie));
        end
        use_model = 0;
        wr_en = 0; cfg_lock = 0; smp_en = 0;
        do_reset();

        // R2 register map and read-zero bits
        reg_wr(2'd0, 8'hFF); rd_chk("R2 enable reg", 2'd0, 8'h0F);
        reg_wr(2'd1, 8'hE4); rd_chk("R2 select reg", 2'd1, 8'hE4);
        reg_wr(2'd3, 8'hAB); rd_chk("R2 irq enable reg", 2'd3, 8'h0B);
        rd_chk("R2 flag reg upper", 2'd2, 8'h00);
        reg_wr(2'd0, 8'h00); reg_wr(2'd3, 8'h00);

        // R3 exact qualification edge for each code (channel i uses code i)
        smp_en = 1'b1;
        for (int ch = 0; ch < 4; ch++) begin
            int nd;
            nd = 2 * ch + 1;
            reg_wr(2'd0, 8'(1 << ch));
            fault_pin[ch] = 1'b1;
            wait_n(nd + 1);
            chk($sformatf("R3 ch%0d not yet", ch), fault_flag[ch], 0);
            tick();
            chk($sformatf("R3 ch%0d set after run", ch), fault_flag[ch], 1);
            chk($sformatf("R12 ch%0d level high", ch), fault_lvl[ch], 1);
            fault_pin[ch] = 1'b0;
            wait_n(3);
            chk($sformatf("R12 ch%0d level low", ch), fault_lvl[ch], 0);
            chk($sformatf("R8 ch%0d sticky", ch), fault_flag[ch], 1);
            reg_wr(2'd2, 8'h0F);
            chk($sformatf("R7 ch%0d cleared", ch), fault_flag[ch], 0);
        end

        // R4 interrupted runs on channel 1 (needs 3)
        reg_wr(2'd0, 8'h02);
        for (int k = 0; k < 6; k++) begin
            fault_pin[1] = 1'b1; wait_n(2);
            fault_pin[1] = 1'b0; wait_n(1);
        end
        wait_n(3);
        chk("R4 broken runs never qualify", fault_flag[1], 0);
        fault_pin[1] = 1'b1; wait_n(6);
        chk("R4 full run qualifies", fault_flag[1], 1);

        // R5 one set per rising edge
        reg_wr(2'd2, 8'h02);
        wait_n(10);
        chk("R5 held pin no reset", fault_flag[1], 0);
        fault_pin[1] = 1'b0; wait_n(4);
        fault_pin[1] = 1'b1; wait_n(6);
        chk("R5 new edge sets", fault_flag[1], 1);
        fault_pin[1] = 1'b0; wait_n(3);
        reg_wr(2'd2, 8'h0F);

        // R6 disabled channel ignored
        reg_wr(2'd0, 8'h0B);
        fault_pin[2] = 1'b1; wait_n(20);
        chk("R6 disabled flag", fault_flag[2], 0);
        chk("R6 disabled level", fault_lvl[2], 0);
        fault_pin[2] = 1'b0;

        // R7 write zero no effect, write one selective
        fault_pin[0] = 1'b1; fault_pin[3] = 1'b1; wait_n(10);
        fault_pin[0] = 1'b0; fault_pin[3] = 1'b0; wait_n(3);
        chk("R7 two flags set", fault_flag, 4'h9);
        reg_wr(2'd2, 8'h00);
        chk("R7 write zero keeps", fault_flag, 4'h9);
        reg_wr(2'd2, 8'h01);
        chk("R7 write one clears bit0 only", fault_flag, 4'h8);

        // R10 interrupt
        chk("R10 no irq when disabled", irq, 0);
        reg_wr(2'd3, 8'h08);
        chk("R10 irq raised", irq, 1);
        reg_wr(2'd2, 8'h08);
        chk("R10 clear drops irq", irq, 0);

        // R9 set beats same-edge clear, channel 0 code 0 (edge 3 after pin rises)
        fault_pin[0] = 1'b1; wait_n(4);
        fault_pin[0] = 1'b0; wait_n(4);
        chk("R9 precondition flag", fault_flag[0], 1);
        fault_pin[0] = 1'b1;
        wait_n(2);
        reg_wr(2'd2, 8'h01);
        chk("R9 set wins", fault_flag[0], 1);
        fault_pin[0] = 1'b0; wait_n(3);
        reg_wr(2'd2, 8'h0F);

        // R13 no strobe no sample
        smp_en = 1'b0;
        fault_pin[3] = 1'b1; wait_n(30);
        chk("R13 no strobe no flag", fault_flag[3], 0);
        for (int k = 0; k < 10; k++) begin
            smp_en = 1'b1; tick();
            smp_en = 1'b0; wait_n(3);
        end
        chk("R13 sparse strobes qualify", fault_flag[3], 1);
        fault_pin[3] = 1'b0; smp_en = 1'b1; wait_n(3);

        // R11 lock
        cfg_lock = 1'b1; tick(); cfg_lock = 1'b0;
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h00);
        rd_chk("R11 enable frozen", 2'd0, 8'h0B);
        rd_chk("R11 select frozen", 2'd1, 8'hE4);
        reg_wr(2'd3, 8'h05);
        rd_chk("R11 irq enable writable", 2'd3, 8'h05);
        reg_wr(2'd2, 8'h0F);
        rd_chk("R11 flags clearable", 2'd2, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule